// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a bus-mapped watchdog that can pull the whole chip into reset. Software loads a tick count, then arms the block through a two-bit configuration field in a separate control register. While armed, an internal prescaler divides the bus clock into a tick enable, and the count drops by one on each tick. When the count has run down to zero, the block raises a reset request for a fixed number of clocks. It also disarms itself and marks a status flag so that software, once running again, can tell why the chip restarted. Writing a fresh count while armed is the keep-alive action.

Every register write must carry the key byte 0x5A in bits 31:24, or the write is dropped. A status register holds a six-bit boot-partition number, spread over the even bit positions. The block has two resets. The power-on reset `rst_n` clears everything. The warm reset `soft_rst_n` is the chip reset, which the request output normally drives. It clears the control field, the count and the prescaler, but it leaves the status register and the request pulse untouched. This lets the partition number and the watchdog flag survive the restart that the block itself caused.

Top module: `wdg_rstctl`

## Requirements
- R1: Registers decode at byte offsets 0x1C (control), 0x20 (status) and 0x24 (count). Reads ignore the key and return bits 31:24 as zero. The control field reads back in bits 5:4, the count in bits 19:0 and the partition in bits 0, 2, 4, 6, 8 and 10. Every other bit reads zero.
- R2: A write whose bits 31:24 differ from 0x5A leaves all three registers unchanged.
- R3: A keyed control write stores bits 5:4 as the configuration field. The watchdog runs exactly when bit 5 is set, so 0x20 arms it. The keyed value 0x102 disarms it and clears the field.
- R4: While armed, the count falls by one every TICK_DIV clocks, counted from the arming or reload write. While disarmed, the count does not change, and the count register reads back the current value.
- R5: A keyed count write while armed reloads the count at once and restarts the prescaler. It leaves the armed state as it was.
- R6: One clock after the count sits at zero while armed, the reset request output goes high for exactly PULSE_CLKS clocks. This happens once per expiry, including when the block is armed with a count of zero.
- R7: On expiry, the configuration field is cleared and status bit 6 is set.
- R8: A keyed status write takes the partition from the even bits 0 to 10 of the written data. The odd bits 1 to 11 are never changed and read as zero.
- R9: A low `soft_rst_n` clears the control field and the count. It keeps the status register and does not shorten a reset request pulse that is already running.
- R10: A low `rst_n` clears every register and the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| soft_rst_n | input | 1 | Warm chip reset, synchronous, active low; status survives it |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data; key byte in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| wd_rst_req | output | 1 | Full-chip reset request pulse |

## Verification
The hardest condition to reach from the ports is the overlap between a running reset request and the warm reset that the request itself would cause. That overlap is the only situation in which the status register and the pulse length prove that they are independent of `soft_rst_n`. The stimulus arms the block with a count of zero so that it expires on the very next clock. It then drops `soft_rst_n` while the pulse is still high, and checks that the request, the partition number and the flag all stay intact. Tick timing is pinned down by sampling the count on every clock after an arming write and after a keep-alive reload. This catches any off-by-one error in where the prescaler restarts.

// File: rtl/wdg_pkg.sv
// Package: shared constants and helpers for the keyed watchdog.
// Assumes 32-bit bus data with the key byte in the top eight bits.
package wdg_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam logic [7:0]  WR_KEY   = 8'h5A;
    localparam int unsigned OFF_CTRL = 32'h1C;
    localparam int unsigned OFF_STAT = 32'h20;
    localparam int unsigned OFF_CNT  = 32'h24;
    localparam int unsigned PART_W   = 6;
    localparam int unsigned STAT_W   = 2 * PART_W;
    localparam int unsigned FLAG_IDX = 3;   // partition bit 3 sits at status bit 6

    // Places partition bits on the even positions of the status word.
    function automatic logic [STAT_W-1:0] part_spread(input logic [PART_W-1:0] p);
        logic [STAT_W-1:0] s;
        s = '0;
        for (int i = 0; i < PART_W; i++) s[2*i] = p[i];
        return s;
    endfunction

    // Collects the even positions of a written word into a partition value.
    function automatic logic [PART_W-1:0] part_gather(input logic [STAT_W-1:0] s);
        logic [PART_W-1:0] p;
        for (int i = 0; i < PART_W; i++) p[i] = s[2*i];
        return p;
    endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
// Module: tick prescaler. Emits a one-clock tick every DIV clocks while
// enabled; a synchronous clear restarts the phase from zero.
// Assumes DIV >= 1.
module wdg_tick_gen #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            assign tick = en && !clr;
        end else begin : g_div
            localparam int unsigned PRE_W = $clog2(DIV);
            localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
            logic [PRE_W-1:0] pre_q;

            assign tick = en && !clr && (pre_q == LAST);

            // Phase counter: holds at zero when cleared or disabled.
            always_ff @(posedge clk) begin
                if (!rst_n || clr || !en) pre_q <= '0;
                else if (pre_q == LAST)   pre_q <= '0;
                else                      pre_q <= pre_q + PRE_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/wdg_countdown.sv
// Module: watchdog count register. Loads on a keyed write, falls by one per
// tick while armed, and flags expiry when it sits at zero while armed.
// Assumes load has priority over a tick in the same clock.
module wdg_countdown #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: reload, or step down on a tick while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n)               cnt_q <= '0;
        else if (load)                           cnt_q <= load_val;
        else if (armed && tick && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign count  = cnt_q;
    assign expire = soft_rst_n && armed && (cnt_q == '0);
endmodule

// File: rtl/wdg_pulse.sv
// Module: reset request stretcher. A start strobe holds the request high for
// LEN clocks. Only the power-on reset clears it, so a warm reset cannot cut it.
// Assumes LEN >= 1.
module wdg_pulse #(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic req
);
    localparam int unsigned LEN_W = $clog2(LEN + 1);
    logic [LEN_W-1:0] left_q;

    // Remaining-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (start)         left_q <= LEN_W'(LEN);
        else if (left_q != '0)  left_q <= left_q - LEN_W'(1);
    end

    assign req = (left_q != '0);
endmodule

// File: rtl/wdg_rstctl.sv
// Module: keyed watchdog reset controller (top). It decodes the three
// registers, checks the write key, holds the control field and the
// partition status, and ties together the prescaler, the countdown and the
// request stretcher.
// Assumes single-cycle register accesses with combinational read data.
module wdg_rstctl
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CNT_W      = 20,
    parameter int unsigned TICK_DIV   = 16,
    parameter int unsigned PULSE_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_rst_req
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

    logic             key_ok, wr_ctrl, wr_stat, wr_cnt;
    logic [1:0]       ctrl_cfg;
    logic [PART_W-1:0] part_q, part_d;
    logic             armed, tick, expire;
    logic [CNT_W-1:0] cnt_q;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Write decode: only keyed writes reach a register.
    always_comb begin
        key_ok  = (bus_wdata[31:24] == WR_KEY);
        wr_ctrl = bus_sel && bus_wr && key_ok && (bus_addr == A_CTRL);
        wr_stat = bus_sel && bus_wr && key_ok && (bus_addr == A_STAT);
        wr_cnt  = bus_sel && bus_wr && key_ok && (bus_addr == A_CNT);
    end

    // Control field: expiry and warm reset clear it, keyed writes set it.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) ctrl_cfg <= 2'b00;
        else if (expire)           ctrl_cfg <= 2'b00;
        else if (wr_ctrl)          ctrl_cfg <= bus_wdata[5:4];
    end

    assign armed = ctrl_cfg[1];

    // Next partition value: a keyed write first, then the expiry flag on top.
    always_comb begin
        part_d = part_q;
        if (wr_stat) part_d = part_gather(bus_wdata[STAT_W-1:0]);
        if (expire)  part_d[FLAG_IDX] = 1'b1;
    end

    // Status register: cleared only at power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) part_q <= '0;
        else        part_q <= part_d;
    end

    wdg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_cnt || !soft_rst_n),
        .en    (armed),
        .tick  (tick)
    );

    wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .load       (wr_cnt),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .tick       (tick),
        .armed      (armed),
        .count      (cnt_q),
        .expire     (expire)
    );

    wdg_pulse #(.LEN(PULSE_CLKS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (expire),
        .req   (wd_rst_req)
    );

    // Read mux: key byte and unused bits read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_CTRL)      bus_rdata[5:4]        = ctrl_cfg;
            else if (bus_addr == A_STAT) bus_rdata[STAT_W-1:0] = part_spread(part_q);
            else if (bus_addr == A_CNT)  bus_rdata[CNT_W-1:0]  = cnt_q;
        end
    end
endmodule

// File: rtl/wdg_rstctl_chk.sv
// Module: property checker for the keyed watchdog, bound to the top.
// Assumes the same synchronous resets as the design.
module wdg_rstctl_chk
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [1:0]        cfg,
    input logic [CNT_W-1:0]  count,
    input logic              expire,
    input logic              req,
    input logic [PART_W-1:0] part
);
    logic bad_wr, cnt_wr, stat_wr;

    assign bad_wr  = bus_sel && bus_wr && (bus_wdata[31:24] != WR_KEY);
    assign cnt_wr  = bus_sel && bus_wr && (bus_wdata[31:24] == WR_KEY)
                     && (bus_addr == ADDR_W'(OFF_CNT));
    assign stat_wr = bus_sel && bus_wr && (bus_wdata[31:24] == WR_KEY)
                     && (bus_addr == ADDR_W'(OFF_STAT));

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && soft_rst_n && !expire) |=> (cfg == $past(cfg) && part == $past(part))) // R2
        else $error("AST_KEY_GUARD");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[1] && soft_rst_n && !cnt_wr) |=> (count == $past(count))) // R4
        else $error("AST_IDLE_HOLD");
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1] && soft_rst_n && !cnt_wr) |=> (CNT_W'($past(count) - count) <= CNT_W'(1))) // R4
        else $error("AST_STEP_ONE");
    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> req) // R6
        else $error("AST_PULSE_START");
    AST_EXPIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!cfg[1] && part[FLAG_IDX])) // R7
        else $error("AST_EXPIRE_DISARM");
    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_n && !stat_wr) |=> (part == $past(part))) // R9
        else $error("AST_STATUS_KEEP");
    AST_WARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> (cfg == 2'b00 && count == '0)) // R9
        else $error("AST_WARM_CLEAR");
endmodule

bind wdg_rstctl wdg_rstctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_n (soft_rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cfg        (ctrl_cfg),
    .count      (cnt_q),
    .expire     (expire),
    .req        (wd_rst_req),
    .part       (part_q)
);

// File: tb/wdg_rstctl_test.sv
`timescale 1ns/1ps
module wdg_rstctl_test;
    localparam int DIV = 4;
    localparam int PLS = 5;
    localparam logic [7:0] A_CTRL = 8'h1C, A_STAT = 8'h20, A_CNT = 8'h24;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst_n = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst_req;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    wdg_rstctl #(.ADDR_W(8), .CNT_W(20), .TICK_DIV(DIV), .PULSE_CLKS(PLS)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req));

    function automatic logic [31:0] spread6(input logic [5:0] p);
        logic [31:0] s = '0;
        for (int i = 0; i < 6; i++) s[2*i] = p[i];
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL timeout actual=%0d expected<%0d", 200000, 200000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [1:0]  m_cfg;
        logic [19:0] m_cnt;
        logic [5:0]  m_part;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1: reset state
        rd(A_CTRL, v); chk("R10 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R10 stat", v, 32'h0);
        rd(A_CNT,  v); chk("R10 cnt",  v, 32'h0);
        chk("R10 req", {31'b0, wd_rst_req}, 32'h0);

        // R1 R2 R3 R8: random keyed/unkeyed writes while disarmed
        m_cfg = 0; m_cnt = 0; m_part = 0;
        for (int it = 0; it < 60; it++) begin
            int sel = $urandom % 3;
            logic [7:0]  key = ($urandom % 2 == 0) ? 8'h5A : (8'h5A ^ 8'(1 + $urandom % 255));
            logic [31:0] d = {key, 24'($urandom)};
            if (sel == 0) begin
                d[5] = 1'b0;
                wr(A_CTRL, d);
                if (key == 8'h5A) m_cfg = d[5:4];
            end else if (sel == 1) begin
                wr(A_STAT, d);
                if (key == 8'h5A) for (int i = 0; i < 6; i++) m_part[i] = d[2*i];
            end else begin
                wr(A_CNT, d);
                if (key == 8'h5A) m_cnt = d[19:0];
            end
            rd(A_CTRL, v); chk("R2/R3 ctrl random", v, {26'b0, m_cfg, 4'b0});
            rd(A_STAT, v); chk("R2/R8 stat random", v, spread6(m_part));
            rd(A_CNT,  v); chk("R1/R4 cnt random",  v, {12'b0, m_cnt});
        end

        // R2: unkeyed arm attempt
        wr(A_CTRL, 32'h5A000000);
        wr(A_CTRL, 32'h12000020);
        rd(A_CTRL, v); chk("R2 bad key arm", v, 32'h0);

        // R8: partition 37 with odd bits also set in the data
        wr(A_STAT, 32'h5A000AAA | spread6(6'd37));
        rd(A_STAT, v); chk("R8 partition", v, 32'h411);

        // R4 R6 R7: count 3 then arm, watch every clock
        wr(A_CNT, 32'h5A000003);
        wr(A_CTRL, 32'h5A000020);
        rd(A_CTRL, v); chk("R3 armed", v, 32'h20);
        for (int j = 1; j <= 3 * DIV; j++) begin
            @(negedge clk);
            rd(A_CNT, v); chk("R4 countdown", v, 32'(3 - j / DIV));
            chk("R6 no early req", {31'b0, wd_rst_req}, 32'h0);
        end
        @(negedge clk);
        chk("R6 req rises", {31'b0, wd_rst_req}, 32'h1);
        rd(A_CTRL, v); chk("R7 disarmed", v, 32'h0);
        rd(A_STAT, v); chk("R7 flag set", v, 32'h451);
        for (int j = 1; j < PLS; j++) begin
            @(negedge clk);
            chk("R6 req held", {31'b0, wd_rst_req}, 32'h1);
        end
        @(negedge clk);
        chk("R6 req falls", {31'b0, wd_rst_req}, 32'h0);
        repeat (10) @(negedge clk);
        chk("R6 single pulse", {31'b0, wd_rst_req}, 32'h0);
        rd(A_CNT, v); chk("R4 idle count", v, 32'h0);

        // R5: keep-alive reload while armed
        wr(A_CNT, 32'h5A000002);
        wr(A_CTRL, 32'h5A000020);
        repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R4 before ping", v, 32'h1);
        wr(A_CNT, 32'h5A000003);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R5 reload holds", v, 32'h3);
        @(negedge clk);
        rd(A_CNT, v); chk("R5 prescaler restart", v, 32'h2);
        rd(A_CTRL, v); chk("R5 still armed", v, 32'h20);

        // R3 R4: disarm with 0x102, count frozen
        wr(A_CTRL, 32'h5A000102);
        rd(A_CTRL, v); chk("R3 disarm", v, 32'h0);
        rd(A_CNT, v);
        repeat (20) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(A_CNT, v2); chk("R4 frozen", v2, v);
        end
        chk("R3 no req", {31'b0, wd_rst_req}, 32'h0);

        // R6 R9: arm at zero, warm reset during the pulse
        wr(A_STAT, 32'h5A000000 | spread6(6'd10));
        wr(A_CNT, 32'h5A000000);
        wr(A_CTRL, 32'h5A000020);
        chk("R6 zero arm delay", {31'b0, wd_rst_req}, 32'h0);
        @(negedge clk);
        chk("R6 zero arm fires", {31'b0, wd_rst_req}, 32'h1);
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        chk("R9 pulse kept", {31'b0, wd_rst_req}, 32'h1);
        rd(A_STAT, v); chk("R9 status kept", v, spread6(6'd10) | 32'h40);
        wr(A_CNT, 32'h5A000077);
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        rd(A_CNT, v);  chk("R9 count cleared", v, 32'h0);
        rd(A_CTRL, v); chk("R9 ctrl cleared", v, 32'h0);

        // R10: power-on reset clears status
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_STAT, v); chk("R10 status cleared", v, 32'h0);
        chk("R10 req cleared", {31'b0, wd_rst_req}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule